// File: doc/BRIEF.md
# Subroutine Call and Stack Sequencer

This block executes the stack-related instructions of a small 8-bit processor core that has a 16-bit program counter. It handles the following instructions:

- an absolute call and a call through a page-zero vector table;
- plain return and return from interrupt;
- push and pop of the status byte or of a 16-bit register pair;
- loading the stack pointer from a register pair, and copying the stack pointer out to one.

The block owns the program counter, the stack pointer and the status byte. It reaches data memory through a byte-wide port that makes one access per clock. A write takes effect in the cycle it is driven. Read data is returned by the memory one clock after the request.

An upstream decoder presents an instruction class and its operands together with a `start` strobe. The cycle in which the strobe is accepted counts as cycle 1. `done` rises in the final cycle of the instruction's fixed clock count. The architectural registers take their new values at the clock edge that closes that cycle. Fetch, decode, the ALU and interrupt arbitration lie outside the block.

Top module: `stk_seq`

## Requirements
- R1: While reset is held and after its release, `pc`, `sp` and `psw` equal their reset parameters. `busy`, `done`, `mem_we`, `mem_re` and `pair_we` are low.
- R2: The `op` codes are: 0 absolute call, 1 vectored call, 2 return, 3 interrupt return, 4 push status, 5 pop status, 6 push pair, 7 pop pair, 8 load SP from pair, 9 copy SP to pair. A `start` while idle with a code from 0 to 9 is accepted. Codes 10 to 15 are ignored. A `start` while busy is ignored.
- R3: `done` is high for one cycle, in cycle N, where cycle 1 is the accepting cycle. N is 6 for codes 0, 2, 7 and 9. N is 8 for codes 1, 3 and 8. N is 4 for codes 5 and 6. N is 2 for code 4.
- R4: The absolute call stores (PC+3) with its high byte at SP-1 and its low byte at SP-2. It then loads PC with `call_tgt` and lowers SP by 2.
- R5: The vectored call stores (PC+1) in the same byte order and lowers SP by 2. It loads the PC low byte from address `vec_sel` zero-extended, and the PC high byte from that address plus 1.
- R6: Return loads the PC low byte from SP and the high byte from SP+1, then raises SP by 2.
- R7: Interrupt return does the same as return, also loads `psw` from SP+2, and raises SP by 3.
- R8: Push status writes `psw` to SP-1 and lowers SP by 1. Pop status loads `psw` from SP and raises SP by 1.
- R9: Push pair writes the high byte of `pair_in` to SP-1 and the low byte to SP-2, and lowers SP by 2. Pop pair presents {(SP+1),(SP)} on `pair_out` with `pair_we` high in the `done` cycle, then raises SP by 2.
- R10: Load-SP sets SP to `pair_in`. Copy-SP presents SP on `pair_out` with `pair_we` high in the `done` cycle.
- R11: Every stack address and every SP update wraps modulo 2^16.
- R12: At most one of `mem_we` and `mem_re` is high in any cycle. No access occurs while idle. Read data is taken from `mem_rdata` one cycle after the request.
- R13: `pc`, `sp` and `psw` change only at the edge that ends a `done` cycle. Codes 4 to 9 leave `pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an instruction |
| op | input | 4 | Instruction class code |
| call_tgt | input | 16 | Absolute call target |
| vec_sel | input | 5 | Vector table slot for the vectored call |
| pair_in | input | 16 | Register pair value for push pair and load-SP |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read request |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| psw | output | 8 | Status byte |
| pair_out | output | 16 | Register pair result |
| pair_we | output | 1 | `pair_out` is valid for the pair register file |

## Verification
A chained program runs every instruction class against a model memory. The stack is first moved, and later pushes are popped back, so the high-byte/low-byte order on the stack is exercised in both directions. Two vector slots are tried: one in the middle of the table and the last slot, 31. Slot 31 shows whether the high-byte fetch address is formed by a 16-bit increment. A push followed by an interrupt return reads a status byte that a plain return would skip. A stack placed at address 0x0001 forces both writes and reads to cross the 0xFFFF/0x0000 boundary. Separate runs issue a code above 9, and a second `start` while busy, to show that neither one touches state.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  parameter int ADDR_W = 16;
  parameter int BYTE_W = 8;
  parameter int OP_W   = 4;
  parameter int VEC_W  = 5;
  parameter int STEP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_CALL_ABS  = 4'd0,
    OP_CALL_VEC  = 4'd1,
    OP_RET       = 4'd2,
    OP_RETI      = 4'd3,
    OP_PUSH_ST   = 4'd4,
    OP_POP_ST    = 4'd5,
    OP_PUSH_PAIR = 4'd6,
    OP_POP_PAIR  = 4'd7,
    OP_SP_LOAD   = 4'd8,
    OP_SP_COPY   = 4'd9
  } op_e;

  // signed small offset added to a stack address, wrapping at 2^ADDR_W
  function automatic logic [ADDR_W-1:0] addr_off(input logic [ADDR_W-1:0] a,
                                                 input logic signed [3:0] d);
    return a + {{(ADDR_W-4){d[3]}}, d};
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] c);
    return c <= OP_W'(9);
  endfunction

  function automatic logic [STEP_W-1:0] op_cycles(input op_e o);
    case (o)
      OP_PUSH_ST:                          return STEP_W'(2);
      OP_POP_ST, OP_PUSH_PAIR:             return STEP_W'(4);
      OP_CALL_VEC, OP_RETI, OP_SP_LOAD:    return STEP_W'(8);
      default:                             return STEP_W'(6);
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] vec_base(input logic [VEC_W-1:0] v);
    return ADDR_W'(v);
  endfunction
endpackage

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op_raw,
  input  logic [ADDR_W-1:0] call_tgt,
  input  logic [VEC_W-1:0]  vec_sel,
  input  logic [ADDR_W-1:0] pair_in,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step,
  output op_e               op_q,
  output logic [ADDR_W-1:0] tgt_q,
  output logic [VEC_W-1:0]  vec_q,
  output logic [ADDR_W-1:0] pair_q
);
  logic accept;
  assign accept = start && !busy && op_known(op_raw);
  assign done   = busy && (step == op_cycles(op_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      op_q   <= OP_CALL_ABS;
      tgt_q  <= '0;
      vec_q  <= '0;
      pair_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      step   <= STEP_W'(2);
      op_q   <= op_e'(op_raw);
      tgt_q  <= call_tgt;
      vec_q  <= vec_sel;
      pair_q <= pair_in;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_hold_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op_q) && $stable(pair_q)));
  p_reject_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op_known(op_raw)) |=> !busy);
endmodule

// File: rtl/stk_seq_bus.sv
module stk_seq_bus
  import stk_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] sp,
  input  logic [BYTE_W-1:0] psw,
  input  logic [ADDR_W-1:0] pair_q,
  input  logic [VEC_W-1:0]  vec_q,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] byte_lo,
  output logic [BYTE_W-1:0] byte_hi,
  output logic [BYTE_W-1:0] byte_x
);
  logic [ADDR_W-1:0] ret_addr;
  logic              cap_lo, cap_hi, cap_x;
  logic              pops_stack;

  assign ret_addr   = (op_q == OP_CALL_VEC) ? addr_off(pc, 4'sd1) : addr_off(pc, 4'sd3);
  assign pops_stack = (op_q == OP_RET) || (op_q == OP_RETI) || (op_q == OP_POP_PAIR)
                   || (op_q == OP_POP_ST);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    if (busy) begin
      case (op_q)
        OP_CALL_ABS, OP_CALL_VEC: begin
          if (step == STEP_W'(2)) begin
            mem_we = 1'b1; mem_addr = addr_off(sp, -4'sd1); mem_wdata = ret_addr[15:8];
          end else if (step == STEP_W'(3)) begin
            mem_we = 1'b1; mem_addr = addr_off(sp, -4'sd2); mem_wdata = ret_addr[7:0];
          end else if (op_q == OP_CALL_VEC && step == STEP_W'(4)) begin
            mem_re = 1'b1; mem_addr = vec_base(vec_q);
          end else if (op_q == OP_CALL_VEC && step == STEP_W'(5)) begin
            mem_re = 1'b1; mem_addr = addr_off(vec_base(vec_q), 4'sd1);
          end
        end
        OP_RET, OP_RETI, OP_POP_PAIR, OP_POP_ST: begin
          if (step == STEP_W'(2)) begin
            mem_re = 1'b1; mem_addr = sp;
          end else if (step == STEP_W'(3) && op_q != OP_POP_ST) begin
            mem_re = 1'b1; mem_addr = addr_off(sp, 4'sd1);
          end else if (step == STEP_W'(4) && op_q == OP_RETI) begin
            mem_re = 1'b1; mem_addr = addr_off(sp, 4'sd2);
          end
        end
        OP_PUSH_ST: begin
          if (step == STEP_W'(2)) begin
            mem_we = 1'b1; mem_addr = addr_off(sp, -4'sd1); mem_wdata = psw;
          end
        end
        OP_PUSH_PAIR: begin
          if (step == STEP_W'(2)) begin
            mem_we = 1'b1; mem_addr = addr_off(sp, -4'sd1); mem_wdata = pair_q[15:8];
          end else if (step == STEP_W'(3)) begin
            mem_we = 1'b1; mem_addr = addr_off(sp, -4'sd2); mem_wdata = pair_q[7:0];
          end
        end
        default: ;
      endcase
    end
  end

  // read data returns one cycle after each request
  assign cap_lo = busy && ((pops_stack && step == STEP_W'(3))
                        || (op_q == OP_CALL_VEC && step == STEP_W'(5)));
  assign cap_hi = busy && (((op_q == OP_RET) || (op_q == OP_RETI) || (op_q == OP_POP_PAIR))
                           && step == STEP_W'(4)
                        || (op_q == OP_CALL_VEC && step == STEP_W'(6)));
  assign cap_x  = busy && (op_q == OP_RETI) && (step == STEP_W'(5));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_lo <= '0;
      byte_hi <= '0;
      byte_x  <= '0;
    end else begin
      if (cap_lo) byte_lo <= mem_rdata;
      if (cap_hi) byte_hi <= mem_rdata;
      if (cap_x)  byte_x  <= mem_rdata;
    end
  end

  p_one_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_re);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
  p_capture_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_lo || cap_hi || cap_x) |-> $past(mem_re));
endmodule

// File: rtl/stk_seq_arch.sv
module stk_seq_arch
  import stk_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PC_RST  = 16'h0100,
  parameter logic [ADDR_W-1:0] SP_RST  = 16'hFF80,
  parameter logic [BYTE_W-1:0] PSW_RST = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] tgt_q,
  input  logic [ADDR_W-1:0] pair_q,
  input  logic [BYTE_W-1:0] byte_lo,
  input  logic [BYTE_W-1:0] byte_hi,
  input  logic [BYTE_W-1:0] byte_x,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic [BYTE_W-1:0] psw,
  output logic [ADDR_W-1:0] pair_out,
  output logic              pair_we
);
  logic [ADDR_W-1:0] popped;
  assign popped   = {byte_hi, byte_lo};
  assign pair_out = (op_q == OP_SP_COPY) ? sp : popped;
  assign pair_we  = done && ((op_q == OP_POP_PAIR) || (op_q == OP_SP_COPY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= PC_RST;
      sp  <= SP_RST;
      psw <= PSW_RST;
    end else if (done) begin
      case (op_q)
        OP_CALL_ABS:  begin pc <= tgt_q;  sp <= addr_off(sp, -4'sd2); end
        OP_CALL_VEC:  begin pc <= popped; sp <= addr_off(sp, -4'sd2); end
        OP_RET:       begin pc <= popped; sp <= addr_off(sp, 4'sd2); end
        OP_RETI:      begin pc <= popped; psw <= byte_x; sp <= addr_off(sp, 4'sd3); end
        OP_PUSH_ST:   sp <= addr_off(sp, -4'sd1);
        OP_POP_ST:    begin psw <= byte_lo; sp <= addr_off(sp, 4'sd1); end
        OP_PUSH_PAIR: sp <= addr_off(sp, -4'sd2);
        OP_POP_PAIR:  sp <= addr_off(sp, 4'sd2);
        OP_SP_LOAD:   sp <= pair_q;
        default: ;
      endcase
    end
  end

  p_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(pc) && $stable(sp) && $stable(psw)));
  p_push_st_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_PUSH_ST) |=> (sp == $past(sp) - 16'd1));
  p_call_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_CALL_ABS) |=> (pc == $past(tgt_q)));
  p_reti_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_RETI) |=> (sp == $past(sp) + 16'd3));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_seq_pkg::*;
#(
  parameter logic [15:0] PC_RST  = 16'h0100,
  parameter logic [15:0] SP_RST  = 16'hFF80,
  parameter logic [7:0]  PSW_RST = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  op,
  input  logic [15:0] call_tgt,
  input  logic [4:0]  vec_sel,
  input  logic [15:0] pair_in,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        mem_re,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc,
  output logic [15:0] sp,
  output logic [7:0]  psw,
  output logic [15:0] pair_out,
  output logic        pair_we
);
  logic [STEP_W-1:0] step;
  op_e               op_q;
  logic [ADDR_W-1:0] tgt_q, pair_q;
  logic [VEC_W-1:0]  vec_q;
  logic [BYTE_W-1:0] byte_lo, byte_hi, byte_x;

  stk_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_raw(op), .call_tgt(call_tgt),
    .vec_sel(vec_sel), .pair_in(pair_in), .busy(busy), .done(done), .step(step),
    .op_q(op_q), .tgt_q(tgt_q), .vec_q(vec_q), .pair_q(pair_q)
  );

  stk_seq_bus u_bus (
    .clk(clk), .rst_n(rst_n), .busy(busy), .step(step), .op_q(op_q), .pc(pc),
    .sp(sp), .psw(psw), .pair_q(pair_q), .vec_q(vec_q), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .byte_lo(byte_lo), .byte_hi(byte_hi), .byte_x(byte_x)
  );

  stk_seq_arch #(.PC_RST(PC_RST), .SP_RST(SP_RST), .PSW_RST(PSW_RST)) u_arch (
    .clk(clk), .rst_n(rst_n), .done(done), .op_q(op_q), .tgt_q(tgt_q),
    .pair_q(pair_q), .byte_lo(byte_lo), .byte_hi(byte_hi), .byte_x(byte_x),
    .pc(pc), .sp(sp), .psw(psw), .pair_out(pair_out), .pair_we(pair_we)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done));
endmodule

// File: tb/stk_seq_tb.sv
module stk_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PC0 = 16'h0100;
  localparam logic [15:0] SP0 = 16'hFF80;
  localparam logic [7:0]  PSW0 = 8'h02;

  // {op[44:41], tgt[40:25], vec[24:20], pair[19:4], cycles[3:0]}
  localparam int NV = 13;
  localparam logic [44:0] VECS [0:NV-1] = '{
    {4'd8, 16'h0000, 5'd0,  16'hFF40, 4'd8},
    {4'd5, 16'h0000, 5'd0,  16'h0000, 4'd4},
    {4'd4, 16'h0000, 5'd0,  16'h0000, 4'd2},
    {4'd0, 16'h1234, 5'd0,  16'h0000, 4'd6},
    {4'd6, 16'h0000, 5'd0,  16'hA55A, 4'd4},
    {4'd7, 16'h0000, 5'd0,  16'h0000, 4'd6},
    {4'd2, 16'h0000, 5'd0,  16'h0000, 4'd6},
    {4'd1, 16'h0000, 5'd5,  16'h0000, 4'd8},
    {4'd1, 16'h0000, 5'd31, 16'h0000, 4'd8},
    {4'd9, 16'h0000, 5'd0,  16'h0000, 4'd6},
    {4'd6, 16'h0000, 5'd0,  16'h1357, 4'd4},
    {4'd3, 16'h0000, 5'd0,  16'h0000, 4'd8},
    {4'd0, 16'h0040, 5'd0,  16'h0000, 4'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] op_i = '0;
  logic [15:0] tgt_i = '0, pair_i = '0;
  logic [4:0] vec_i = '0;
  logic [7:0] mem_rdata = '0;
  logic [15:0] mem_addr, pc, sp, pair_out;
  logic [7:0] mem_wdata, psw;
  logic mem_we, mem_re, busy, done, pair_we;

  int checks = 0, failures = 0, overlap = 0;
  logic [7:0] dmem [0:511];
  logic [7:0] mmem [0:511];
  logic [15:0] m_pc, m_sp;
  logic [7:0]  m_psw;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq #(.PC_RST(PC0), .SP_RST(SP0), .PSW_RST(PSW0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .call_tgt(tgt_i),
    .vec_sel(vec_i), .pair_in(pair_i), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .busy(busy),
    .done(done), .pc(pc), .sp(sp), .psw(psw), .pair_out(pair_out), .pair_we(pair_we)
  );

  function automatic int mi(input logic [15:0] a);
    return int'({a[15], a[7:0]});
  endfunction

  always @(posedge clk) begin
    if (mem_we) dmem[mi(mem_addr)] <= mem_wdata;
    if (mem_re) mem_rdata <= dmem[mi(mem_addr)];
  end

  always @(negedge clk) begin
    if (rst_n && mem_we && mem_re) overlap++;
    if (rst_n && !busy && (mem_we || mem_re)) overlap++;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R4";
      4'd1: return "R5";
      4'd2: return "R6";
      4'd3: return "R7";
      4'd4, 4'd5: return "R8";
      4'd6, 4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [15:0] tg, input logic [4:0] vc,
                       input logic [15:0] pr, output logic [15:0] ep, output bit epwe);
    logic [15:0] r;
    ep = '0; epwe = 1'b0;
    case (o)
      4'd0, 4'd1: begin
        r = (o == 4'd0) ? m_pc + 16'd3 : m_pc + 16'd1;
        mmem[mi(m_sp - 16'd1)] = r[15:8];
        mmem[mi(m_sp - 16'd2)] = r[7:0];
        if (o == 4'd0) m_pc = tg;
        else m_pc = {mmem[mi({11'd0, vc} + 16'd1)], mmem[mi({11'd0, vc})]};
        m_sp = m_sp - 16'd2;
      end
      4'd2, 4'd3: begin
        m_pc = {mmem[mi(m_sp + 16'd1)], mmem[mi(m_sp)]};
        if (o == 4'd3) begin m_psw = mmem[mi(m_sp + 16'd2)]; m_sp = m_sp + 16'd3; end
        else m_sp = m_sp + 16'd2;
      end
      4'd4: begin mmem[mi(m_sp - 16'd1)] = m_psw; m_sp = m_sp - 16'd1; end
      4'd5: begin m_psw = mmem[mi(m_sp)]; m_sp = m_sp + 16'd1; end
      4'd6: begin
        mmem[mi(m_sp - 16'd1)] = pr[15:8];
        mmem[mi(m_sp - 16'd2)] = pr[7:0];
        m_sp = m_sp - 16'd2;
      end
      4'd7: begin
        ep = {mmem[mi(m_sp + 16'd1)], mmem[mi(m_sp)]}; epwe = 1'b1;
        m_sp = m_sp + 16'd2;
      end
      4'd8: m_sp = pr;
      default: begin ep = m_sp; epwe = 1'b1; end
    endcase
  endtask

  task automatic exec(input logic [3:0] o, input logic [15:0] tg, input logic [4:0] vc,
                      input logic [15:0] pr, input logic [3:0] cyc, input bit inject);
    int k;
    logic [15:0] seen_pair, ep;
    bit seen_pwe, epwe;
    int bad;
    string t;
    t = tag_of(o);
    @(negedge clk);
    start = 1'b1; op_i = o; tgt_i = tg; vec_i = vc; pair_i = pr;
    @(negedge clk);
    start = 1'b0; k = 2;
    if (inject) begin start = 1'b1; op_i = 4'd8; pair_i = 16'h0000; end  // R2 start while busy
    while (!done && k < 40) begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    seen_pwe = pair_we; seen_pair = pair_out;
    chk(done && k == int'(cyc), "R3", $sformatf("op %0d clock count", o), k, cyc);
    model(o, tg, vc, pr, ep, epwe);
    @(negedge clk);
    chk(pc == m_pc, (o >= 4'd4) ? "R13" : t, "pc", pc, m_pc);
    chk(sp == m_sp, t, "sp", sp, m_sp);
    chk(psw == m_psw, t, "psw", psw, m_psw);
    chk(!busy, inject ? "R2" : t, "busy after done", busy, 0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (dmem[i] !== mmem[i]) bad++;
    chk(bad == 0, t, "memory bytes differing", bad, 0);
    chk(seen_pwe == epwe, t, "pair_we", seen_pwe, epwe);
    if (epwe) chk(seen_pair == ep, t, "pair_out", seen_pair, ep);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      dmem[i] = 8'(i * 37 + 11);
      mmem[i] = 8'(i * 37 + 11);
    end
    m_pc = PC0; m_sp = SP0; m_psw = PSW0;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk(pc == PC0 && sp == SP0 && psw == PSW0, "R1", "regs in reset", {pc, sp}, {PC0, SP0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_we && !mem_re && !pair_we, "R1", "idle outputs",
        {busy, done, mem_we, mem_re, pair_we}, 0);
    chk(psw == PSW0, "R1", "psw after reset", psw, PSW0);

    for (int v = 0; v < NV; v++)
      exec(VECS[v][44:41], VECS[v][40:25], VECS[v][24:20], VECS[v][19:4], VECS[v][3:0], 1'b0);

    // R2: start during busy is ignored (load-SP of 0 must not happen)
    exec(4'd0, 16'h2222, 5'd0, 16'h0000, 4'd6, 1'b1);

    // R2: unknown code ignored
    @(negedge clk);
    start = 1'b1; op_i = 4'd12; pair_i = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R2", "code 12 accepted", busy, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done && sp == m_sp && pc == m_pc, "R2", "state after code 12",
        {pc, sp}, {m_pc, m_sp});

    // R11: stack crossing the address wrap
    exec(4'd8, 16'h0000, 5'd0, 16'h0001, 4'd8, 1'b0);
    exec(4'd6, 16'h0000, 5'd0, 16'hBEEF, 4'd4, 1'b0);
    chk(sp == 16'hFFFF, "R11", "sp wrapped down", sp, 16'hFFFF);
    chk(dmem[mi(16'h0000)] == 8'hBE && dmem[mi(16'hFFFF)] == 8'hEF, "R11", "wrapped bytes",
        {dmem[mi(16'h0000)], dmem[mi(16'hFFFF)]}, 16'hBEEF);
    exec(4'd7, 16'h0000, 5'd0, 16'h0000, 4'd6, 1'b0);
    chk(sp == 16'h0001, "R11", "sp wrapped up", sp, 16'h0001);

    chk(overlap == 0, "R12", "cycles with overlap or idle access", overlap, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule